// File: doc/BRIEF.md
# Sample Threshold Alert Comparator

This block watches a stream of signed conversion results. Each result arrives on a sample strobe. The block drives an alert pin once a programmable number of consecutive results have gone out of range. It holds four 16-bit registers behind a simple address/data port: the latest result, a configuration word, a low threshold and a high threshold. All values are left-aligned two's-complement words. A converter narrower than 16 bits puts its result in the top bits.

The comparator has two modes:
- **Traditional mode** uses the upper threshold to trip the alert and the lower threshold as the release point, which gives hysteresis.
- **Window mode** flags any result outside the closed range from low to high.

The alert can be latched. A latched alert stays asserted until the result register is read. The active level of the pin can be programmed. A queue code of 3 turns the comparator off.

A state machine (`sac_alert_fsm`) decides the alert. It has three states:
- **IDLE**: the comparator is off.
- **WATCH**: the comparator is armed and counting.
- **ACTIVE**: the alert is asserted.

Its transitions are:
- **ARM** (IDLE to WATCH): a configuration write with an enabled queue code.
- **DISARM** (any state to IDLE): a configuration write with queue code 3.
- **TRIP** (WATCH to ACTIVE): the run of exceeding samples reaches the limit.
- **RELEASE** (ACTIVE to WATCH): a releasing sample arrives while latching is off.
- **ACK** (ACTIVE to WATCH): the result register is read while latching is on.

Top module: `sample_alert_cmp`

## Requirements
- R1: After reset the registers read as follows, and the alert pin is high (inactive for polarity 0):
  - address 0 (result) reads 0x0000;
  - address 1 (configuration) reads 0x0003;
  - address 2 (low threshold) reads 0x8000;
  - address 3 (high threshold) reads 0x7FFF.
- R2: A read strobe at address A presents that register's value on `reg_rdata` in the cycle after the strobe. Address 0 returns the last strobed sample. Writes to address 0 have no effect.
- R3: Addresses 1 to 3 store all 16 written bits and read them back. Configuration bits 15:5 have no effect on the alert.
- R4: Configuration bits [1:0] hold the queue code. Codes 0, 1 and 2 assert the alert after the clock edge of the 1st, 2nd or 4th consecutive exceeding sample.
- R5: A non-exceeding sample restarts the consecutive count.
- R6: A configuration write restarts the consecutive count. An alert that is already asserted stays asserted unless the new queue code is 3.
- R7: Queue code 3 forces the alert inactive, and writing it clears an asserted alert at once.
- R8: Configuration bit 3 sets the pin level. With 0 the pin is low while asserted; with 1 it is high while asserted.
- R9: With configuration bit 4 = 0 (traditional), a sample exceeds when it is greater than the high threshold. When not latched, the alert deasserts on a sample at or below the low threshold. Samples in between leave it unchanged.
- R10: With bit 4 = 1 (window), a sample exceeds when it is above the high threshold or below the low threshold. When not latched, the alert deasserts on the first sample inside the window.
- R11: With configuration bit 2 = 1 (latched), an asserted alert ignores samples. It deasserts after the edge of a read strobe to address 0. Reads of other addresses leave it asserted.
- R12: Sample data presented without the strobe changes neither the result register nor the alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Left-aligned signed sample |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| alert | output | 1 | Alert pin, level set by polarity bit |

## Verification
The embedded assertions check these rules on every cycle:
- the consecutive count never passes four, and it restarts after a non-exceeding sample or a configuration write;
- a latched alert holds until the acknowledging read, and that read clears it;
- writing queue code 3 silences the alert;
- register reads return the stored value one cycle later, and writes to address 0 leave the result register unchanged.

The trip points for each queue length, the hysteresis band of traditional mode, window release and pin polarity come from the bench's sweep. That sweep covers every combination of queue code, mode, latching and polarity, checking each sample against an arithmetic reference.

// File: rtl/sac_pkg.sv
package sac_pkg;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] A_CONV = 2'd0;
    localparam logic [REG_AW-1:0] A_CFG  = 2'd1;
    localparam logic [REG_AW-1:0] A_LO   = 2'd2;
    localparam logic [REG_AW-1:0] A_HI   = 2'd3;

    localparam int CFG_LATCH_BIT = 2;
    localparam int CFG_POL_BIT   = 3;
    localparam int CFG_MODE_BIT  = 4;

    localparam logic [1:0] Q_OFF = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WATCH  = 2'd1,
        ST_ACTIVE = 2'd2
    } alert_st_e;

    typedef struct packed {
        logic [1:0] queue;
        logic       latch;
        logic       pol;
        logic       window;
    } cmp_cfg_t;

    // number of consecutive exceeding samples required by a queue code
    function automatic logic [3:0] run_limit(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/sac_regfile.sv
module sac_regfile
    import sac_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [DATA_W-1:0]   smp_data,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output cmp_cfg_t            cfg,
    output logic [DATA_W-1:0]   lo_thr,
    output logic [DATA_W-1:0]   hi_thr,
    output logic                cfg_wr,
    output logic [1:0]          wr_code,
    output logic                conv_rd
);

    localparam logic [DATA_W-1:0] RST_CFG = DATA_W'(3);
    localparam logic [DATA_W-1:0] RST_LO  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] RST_HI  = {1'b0, {(DATA_W-1){1'b1}}};
    localparam int               N_THR    = 2;

    logic [DATA_W-1:0] conv_q;
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] thr_q [N_THR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         conv_q <= '0;
        else if (smp_valid) conv_q <= smp_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= RST_CFG;
        else if (cfg_wr) cfg_q <= reg_wdata;
    end

    // threshold registers: index 0 = low (address 2), index 1 = high (address 3)
    for (genvar t = 0; t < N_THR; t++) begin : g_thr
        localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(2 + t);
        localparam logic [DATA_W-1:0] MY_RST  = (t == 0) ? RST_LO : RST_HI;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          thr_q[t] <= MY_RST;
            else if (reg_wr && reg_addr == MY_ADDR) thr_q[t] <= reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            unique case (reg_addr)
                A_CONV:  reg_rdata <= conv_q;
                A_CFG:   reg_rdata <= cfg_q;
                A_LO:    reg_rdata <= thr_q[0];
                default: reg_rdata <= thr_q[1];
            endcase
        end
    end

    always_comb begin
        cfg_wr       = reg_wr && (reg_addr == A_CFG);
        wr_code      = reg_wdata[1:0];
        conv_rd      = reg_rd && (reg_addr == A_CONV);
        cfg.queue    = cfg_q[1:0];
        cfg.latch    = cfg_q[CFG_LATCH_BIT];
        cfg.pol      = cfg_q[CFG_POL_BIT];
        cfg.window   = cfg_q[CFG_MODE_BIT];
        lo_thr       = thr_q[0];
        hi_thr       = thr_q[1];
    end

    // R2
    cfg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_CFG) |=> (reg_rdata == $past(cfg_q)));

    // R2
    conv_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CONV && !smp_valid) |=> $stable(conv_q));

endmodule

// File: rtl/sac_qualifier.sv
module sac_qualifier
    import sac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RUN_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic [DATA_W-1:0]  smp_data,
    input  logic [DATA_W-1:0]  lo_thr,
    input  logic [DATA_W-1:0]  hi_thr,
    input  logic               window,
    input  logic [1:0]         queue,
    input  logic               run_clr,
    output logic               run_met,
    output logic               back_in
);

    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(4);

    logic             above_hi;
    logic             below_lo;
    logic             at_or_below_lo;
    logic             over_hit;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_next;

    always_comb begin
        above_hi       = $signed(smp_data) >  $signed(hi_thr);
        below_lo       = $signed(smp_data) <  $signed(lo_thr);
        at_or_below_lo = $signed(smp_data) <= $signed(lo_thr);
        over_hit       = window ? (above_hi || below_lo) : above_hi;
        run_next       = (run_q == RUN_MAX) ? RUN_MAX : run_q + 1'b1;
        run_met        = smp_valid && over_hit &&
                         ({{(4-RUN_W){1'b0}}, run_next} >= run_limit(queue));
        back_in        = smp_valid && (window ? !over_hit : at_or_below_lo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (run_clr)   run_q <= '0;
        else if (smp_valid) run_q <= over_hit ? run_next : '0;
    end

    // R4
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_MAX);

    // R5
    run_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !over_hit) |=> (run_q == '0));

    // R6
    run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_clr |=> (run_q == '0));

endmodule

// File: rtl/sac_alert_fsm.sv
module sac_alert_fsm
    import sac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] wr_code,
    input  logic       latch,
    input  logic       pol,
    input  logic       run_met,
    input  logic       back_in,
    input  logic       conv_rd,
    output logic       ack,
    output logic       alert
);

    alert_st_e state_q;
    alert_st_e state_d;
    logic      fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            if (wr_code == Q_OFF)         state_d = ST_IDLE;   // DISARM
            else if (state_q == ST_IDLE)  state_d = ST_WATCH;  // ARM
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_WATCH:  if (run_met) state_d = ST_ACTIVE;   // TRIP
                ST_ACTIVE: begin
                    if (latch) begin
                        if (conv_rd) state_d = ST_WATCH;       // ACK
                    end else if (back_in) begin
                        state_d = ST_WATCH;                    // RELEASE
                    end
                end
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        fire  = (state_q == ST_ACTIVE);
        ack   = fire && latch && conv_rd && !cfg_wr;
        alert = pol ? fire : !fire;
    end

    // R7
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && wr_code == Q_OFF) |=> (state_q == ST_IDLE));

    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && latch && !conv_rd && !cfg_wr) |=> (state_q == ST_ACTIVE));

    // R11
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && latch && conv_rd && !cfg_wr) |=> (state_q == ST_WATCH));

endmodule

// File: rtl/sample_alert_cmp.sv
module sample_alert_cmp
    import sac_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              alert
);

    localparam int RUN_W = 3;

    cmp_cfg_t          cfg;
    logic [DATA_W-1:0] lo_thr;
    logic [DATA_W-1:0] hi_thr;
    logic              cfg_wr;
    logic [1:0]        wr_code;
    logic              conv_rd;
    logic              run_met;
    logic              back_in;
    logic              ack;
    logic              run_clr;

    assign run_clr = cfg_wr || ack;

    sac_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg),
        .lo_thr    (lo_thr),
        .hi_thr    (hi_thr),
        .cfg_wr    (cfg_wr),
        .wr_code   (wr_code),
        .conv_rd   (conv_rd)
    );

    sac_qualifier #(.DATA_W(DATA_W), .RUN_W(RUN_W)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .lo_thr    (lo_thr),
        .hi_thr    (hi_thr),
        .window    (cfg.window),
        .queue     (cfg.queue),
        .run_clr   (run_clr),
        .run_met   (run_met),
        .back_in   (back_in)
    );

    sac_alert_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .wr_code (wr_code),
        .latch   (cfg.latch),
        .pol     (cfg.pol),
        .run_met (run_met),
        .back_in (back_in),
        .conv_rd (conv_rd),
        .ack     (ack),
        .alert   (alert)
    );

endmodule

// File: tb/sample_alert_cmp_bench.sv
module sample_alert_cmp_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic        reg_wr;
    logic        reg_rd;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        alert;

    always #2 clk = ~clk;

    sample_alert_cmp u_sample_alert_cmp (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alert(alert)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state derived from the requirements
    logic [15:0]        cfg_m;
    logic signed [15:0] lo_m, hi_m;
    logic [15:0]        conv_m;
    bit                 armed_m, fire_m;
    int                 run_m;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_pin();
        return cfg_m[3] ? fire_m : !fire_m;
    endfunction

    task automatic do_wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        if (a == 2'd1) begin
            cfg_m = d; run_m = 0;
            if (d[1:0] == 2'd3) begin armed_m = 0; fire_m = 0; end
            else armed_m = 1;
        end else if (a == 2'd2) lo_m = d;
        else if (a == 2'd3) hi_m = d;
    endtask

    task automatic do_rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        d = reg_rdata;
        if (a == 2'd0 && fire_m && cfg_m[2]) begin fire_m = 0; run_m = 0; end
    endtask

    task automatic do_smp(logic signed [15:0] s);
        bit exc, rel;
        int lim;
        @(negedge clk);
        smp_valid = 1'b1; smp_data = s;
        @(posedge clk); #1;
        smp_valid = 1'b0;
        conv_m = s;
        exc = cfg_m[4] ? (s > hi_m || s < lo_m) : (s > hi_m);
        rel = cfg_m[4] ? !exc : (s <= lo_m);
        run_m = exc ? ((run_m < 4) ? run_m + 1 : 4) : 0;
        lim = 1 << cfg_m[1:0];
        if (armed_m) begin
            if (!fire_m) begin
                if (exc && run_m >= lim) fire_m = 1;
            end else if (!cfg_m[2] && rel) fire_m = 0;
        end
    endtask

    localparam int NSEQ = 16;
    function automatic logic signed [15:0] seq_val(int i);
        case (i)
            0: return 300;   1: return 0;     2: return 300;   3: return 300;
            4: return 300;   5: return 300;   6: return 150;   7: return -150;
            8: return 250;   9: return 260;   10: return 270;  11: return 280;
            12: return -50;  13: return -300; 14: return -300; default: return 0;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        rst_n = 1'b0; smp_valid = 0; smp_data = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        cfg_m = 16'h0003; lo_m = 16'h8000; hi_m = 16'h7FFF; conv_m = 0;
        armed_m = 0; fire_m = 0; run_m = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        chk("R1 alert", {15'd0, alert}, 16'd1);
        do_rd(2'd0, rd); chk("R1 conv", rd, 16'h0000);
        do_rd(2'd1, rd); chk("R1 cfg", rd, 16'h0003);
        do_rd(2'd2, rd); chk("R1 lo", rd, 16'h8000);
        do_rd(2'd3, rd); chk("R1 hi", rd, 16'h7FFF);

        // R2 address 0 not writable; sample readback
        do_wr(2'd0, 16'h1234);
        do_rd(2'd0, rd); chk("R2 conv write ignored", rd, 16'h0000);
        do_smp(16'sh0ABC);
        do_rd(2'd0, rd); chk("R2 conv last sample", rd, 16'h0ABC);

        // R3 full-word readback; upper config bits inert
        do_wr(2'd2, -16'sd100);
        do_wr(2'd3, 16'sd200);
        do_rd(2'd2, rd); chk("R3 lo readback", rd, 16'hFF9C);
        do_rd(2'd3, rd); chk("R3 hi readback", rd, 16'h00C8);
        do_wr(2'd1, 16'hFFE0);  // queue 0, trad, unlatched, active-low, junk above
        do_rd(2'd1, rd); chk("R3 cfg readback", rd, 16'hFFE0);
        do_smp(300);
        chk("R3 junk bits inert trip", {15'd0, alert}, {15'd0, exp_pin()});
        chk("R3 junk bits alert low", {15'd0, alert}, 16'd0);

        // R12 data without strobe ignored
        @(negedge clk); smp_data = -16'sd500;
        repeat (3) @(posedge clk); #1;
        chk("R12 alert held", {15'd0, alert}, 16'd0);
        do_rd(2'd0, rd); chk("R12 conv unchanged", rd, 16'd300);

        // R7 writing code 3 clears asserted alert
        do_wr(2'd1, 16'h0003);
        chk("R7 disarm clears", {15'd0, alert}, 16'd1);
        do_smp(300); do_smp(300);
        chk("R7 off ignores samples", {15'd0, alert}, 16'd1);

        // R6 config write restarts run; alert kept when enabled
        do_wr(2'd1, 16'h0001);  // queue 1: two samples
        do_smp(300);
        do_wr(2'd1, 16'h0001);
        do_smp(300);
        chk("R6 run restarted", {15'd0, alert}, {15'd0, exp_pin()});
        chk("R6 no trip yet", {15'd0, alert}, 16'd1);
        do_smp(300);
        chk("R6 trip after two", {15'd0, alert}, 16'd0);
        do_wr(2'd1, 16'h0002);
        chk("R6 alert kept on rewrite", {15'd0, alert}, 16'd0);

        // R11 other reads do not clear latched alert
        do_wr(2'd1, 16'h0003);
        do_wr(2'd1, 16'h0004);  // latched, queue 0
        do_smp(300);
        chk("R11 latched set", {15'd0, alert}, 16'd0);
        do_smp(-300);
        chk("R11 samples ignored", {15'd0, alert}, 16'd0);
        do_rd(2'd2, rd);
        chk("R11 lo read keeps", {15'd0, alert}, 16'd0);
        do_rd(2'd0, rd);
        chk("R11 conv read clears", {15'd0, alert}, 16'd1);

        // sweep: R4 R5 R8 R9 R10 R11 over every queue/latch/polarity/mode
        for (int w = 0; w < 2; w++)
            for (int p = 0; p < 2; p++)
                for (int l = 0; l < 2; l++)
                    for (int q = 0; q < 3; q++) begin
                        do_wr(2'd1, 16'h0003);
                        do_wr(2'd1, {11'd0, w[0], p[0], l[0], q[1:0]});
                        chk("R8 idle level", {15'd0, alert}, {15'd0, exp_pin()});
                        for (int i = 0; i < NSEQ; i++) begin
                            do_smp(seq_val(i));
                            chk("R4 R5 R9 R10 sweep", {15'd0, alert}, {15'd0, exp_pin()});
                            if (i == 8) begin
                                do_rd(2'd0, rd);
                                chk("R2 sweep conv", rd, conv_m);
                                chk("R11 sweep ack", {15'd0, alert}, {15'd0, exp_pin()});
                            end
                        end
                    end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule